// File: doc/BRIEF.md
# Video Gain and Black-Level Loop Controller

This block is the digital half of the gain and black-level loops of a video digitiser. It runs on the pixel clock. On each clock it receives the 8-bit converter sample, an underflow flag and an overflow flag, plus two strobes from the line timing. One strobe marks the sync tip and the other marks the back porch. From these it issues one charge-pump command for the gain-control capacitor and one for the black-level clamp capacitor. The charge pumps, the amplifier and the converter sit outside the block.

The block runs in one of two modes. In the coarse mode the gain is pushed so that sync lands at code 0 and the peak lands at the top code. The block moves to the fine mode once the line timing looks trustworthy, meaning a set number of consecutive lines in which a long-enough sync-tip pulse is followed within a window by a long-enough back-porch pulse. In the fine mode the black level is held at code 64, the sync tip is held at code 0, and a peak limiter forces the strongest gain reduction whenever a sample passes code 248. If lines stop pairing up, the block falls back to the coarse mode.

Top module: `vid_gain_clamp_ctrl`

## Requirements
- R1: While reset is low, and on its release, both commands are OFF (0) and fine_mode_o is 0, which means coarse mode.
- R2: The commands are registered. A sample presented before clock edge k is reflected only after edge k. The encoding is OFF=0, small charge=1, small discharge=2, large charge=3, large discharge=4, maximum=5.
- R3: In coarse mode the gain command is maximum (5) when over_i is set. Otherwise it is a small discharge (2). This holds on every sample, whatever the strobes are doing.
- R4: In coarse mode the clamp acts only while the sync strobe is high and the porch strobe is low. In that case under_i gives maximum (5), a code above 0 or over_i gives a small discharge (2), and code 0 gives OFF. In every other case the clamp is OFF.
- R5: In fine mode, a code above PEAK_CODE (default 248) or over_i gives a gain command of maximum (5), whatever the strobes are.
- R6: In fine mode with no over-range, the sync strobe gives these gain commands: under_i gives a small charge (1), codes 1..PEAK_CODE give a small discharge (2), and code 0 gives OFF. Without the sync strobe the gain command is OFF.
- R7: In fine mode the clamp follows the porch strobe, including when both strobes are high. Codes below BLACK_CODE (default 64), or under_i, give a large charge (3). Codes above it, or over_i, give a large discharge (4). Code 64 gives OFF. With the porch strobe low the clamp is OFF.
- R8: A strobe pulse counts only if it stays high for at least MIN_HIGH samples. It is recognised on the first low sample after it. Shorter pulses never advance mode qualification.
- R9: A pair is a qualified sync pulse end followed by a qualified porch pulse end within WIN samples. When the N_PAIRS-th consecutive pair is seen, fine_mode_o rises on the next edge.
- R10: If LINE_LEN samples pass without a pair, that is a missed line and the pair count is cleared. After M_MISS consecutive missed lines the block returns to coarse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | CODE_W | Converter sample |
| under_i | input | 1 | Sample is below code 0 |
| over_i | input | 1 | Sample is above the top code |
| sync_gate_i | input | 1 | Sync-tip strobe |
| porch_gate_i | input | 1 | Back-porch strobe |
| gain_cmd_o | output | 3 | Gain capacitor pump command |
| clamp_cmd_o | output | 3 | Clamp capacitor pump command |
| fine_mode_o | output | 1 | 1 = fine mode, 0 = coarse mode |

## Verification
The bench drives whole synthetic lines, and each kind of line separates one decision. Lines with pulses one sample short of the minimum show whether qualification counts the high time. Lines whose porch arrives after the window show whether pairing is timed. Well-formed lines show the qualification threshold being reached. Overlapping strobes in fine mode separate the priority of the gain loop from that of the clamp loop. The sample codes within each strobe step across 0, 63/64/65 and 248/249, and include both flags, so every comparison boundary is crossed in both modes. Idle stretches after acquisition check that one missed line is tolerated and that the fallback happens at the stated count.

// File: rtl/vgc_pkg.sv
`timescale 1ns/1ps
package vgc_pkg;
   localparam int CMD_W = 3;
   // pump command encoding (R2)
   typedef enum logic [CMD_W-1:0] {
      PUMP_OFF  = 3'd0,
      PUMP_UP_S = 3'd1,
      PUMP_DN_S = 3'd2,
      PUMP_UP_L = 3'd3,
      PUMP_DN_L = 3'd4,
      PUMP_MAX  = 3'd5
   } pump_cmd_e;
endpackage

// File: rtl/vgc_pulse_qual.sv
`timescale 1ns/1ps
// Measures one strobe's high time and flags a qualified pulse end (R8).
module vgc_pulse_qual #(
   parameter int MIN_HIGH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic valid_end_o
);
   localparam int CW = $clog2(MIN_HIGH + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MIN_HIGH);

   logic [CW-1:0] hi_cnt;
   logic          strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= strobe_i;
         if (!strobe_i)
            hi_cnt <= '0;
         else if (hi_cnt != LIMIT)
            hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assign valid_end_o = strobe_q && !strobe_i && (hi_cnt == LIMIT);
endmodule

// File: rtl/vgc_mode_fsm.sv
`timescale 1ns/1ps
// Line pairing, qualification and fallback (R9, R10).
module vgc_mode_fsm #(
   parameter int WIN      = 512,
   parameter int LINE_LEN = 2048,
   parameter int N_PAIRS  = 4,
   parameter int M_MISS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_end_i,
   input  logic porch_end_i,
   output logic fine_o
);
   localparam int WW = $clog2(WIN + 1);
   localparam int TW = $clog2(LINE_LEN);
   localparam int GW = $clog2(N_PAIRS + 1);
   localparam int MW = $clog2(M_MISS + 1);
   localparam logic [WW-1:0] WIN_LD   = WW'(WIN);
   localparam logic [TW-1:0] TMR_LAST = TW'(LINE_LEN - 1);
   localparam logic [GW-1:0] GOOD_MAX = GW'(N_PAIRS);
   localparam logic [MW-1:0] MISS_MAX = MW'(M_MISS);

   logic [WW-1:0] win_cnt;
   logic [TW-1:0] line_tmr;
   logic [GW-1:0] good_cnt;
   logic [MW-1:0] miss_cnt;
   logic          win_open, pair_hit, line_miss;

   assign win_open  = (win_cnt != '0);
   assign pair_hit  = porch_end_i && win_open;
   assign line_miss = !pair_hit && (line_tmr == TMR_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt  <= '0;
         line_tmr <= '0;
         good_cnt <= '0;
         miss_cnt <= '0;
         fine_o   <= 1'b0;
      end else begin
         // pairing window opened by a qualified sync end
         if (sync_end_i)
            win_cnt <= WIN_LD;
         else if (pair_hit)
            win_cnt <= '0;
         else if (win_open)
            win_cnt <= win_cnt - 1'b1;

         // line timer restarts on each pair or on a missed line
         if (pair_hit || line_miss)
            line_tmr <= '0;
         else
            line_tmr <= line_tmr + 1'b1;

         if (pair_hit) begin
            if (good_cnt != GOOD_MAX)
               good_cnt <= good_cnt + 1'b1;
            miss_cnt <= '0;
            if (int'(good_cnt) + 1 >= N_PAIRS)
               fine_o <= 1'b1;
         end else if (line_miss) begin
            good_cnt <= '0;
            if (miss_cnt != MISS_MAX)
               miss_cnt <= miss_cnt + 1'b1;
            if (int'(miss_cnt) + 1 >= M_MISS)
               fine_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vgc_pump_decode.sv
`timescale 1ns/1ps
// Per-sample comparators and registered pump commands (R2..R7).
module vgc_pump_decode
   import vgc_pkg::*;
#(
   parameter int CODE_W     = 8,
   parameter int PEAK_CODE  = 248,
   parameter int BLACK_CODE = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fine_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              under_i,
   input  logic              over_i,
   input  logic              sync_i,
   input  logic              porch_i,
   output logic [CMD_W-1:0]  gain_cmd_o,
   output logic [CMD_W-1:0]  clamp_cmd_o
);
   localparam logic [CODE_W-1:0] PEAK  = CODE_W'(PEAK_CODE);
   localparam logic [CODE_W-1:0] BLACK = CODE_W'(BLACK_CODE);

   pump_cmd_e gain_d, clamp_d;
   logic      above_peak, below_black, above_black, code_zero;

   assign above_peak  = over_i || (!under_i && code_i > PEAK);
   assign below_black = under_i || (!over_i && code_i < BLACK);
   assign above_black = over_i || (!under_i && code_i > BLACK);
   assign code_zero   = !under_i && !over_i && (code_i == '0);

   always_comb begin
      gain_d = PUMP_OFF;
      if (!fine_i) begin
         gain_d = over_i ? PUMP_MAX : PUMP_DN_S;               // R3
      end else if (above_peak) begin
         gain_d = PUMP_MAX;                                    // R5
      end else if (sync_i) begin
         if (under_i)        gain_d = PUMP_UP_S;               // R6
         else if (!code_zero) gain_d = PUMP_DN_S;
      end
   end

   always_comb begin
      clamp_d = PUMP_OFF;
      if (!fine_i) begin
         if (sync_i && !porch_i) begin                         // R4
            if (under_i)         clamp_d = PUMP_MAX;
            else if (!code_zero) clamp_d = PUMP_DN_S;
         end
      end else if (porch_i) begin                              // R7
         if (below_black)      clamp_d = PUMP_UP_L;
         else if (above_black) clamp_d = PUMP_DN_L;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_cmd_o  <= PUMP_OFF;
         clamp_cmd_o <= PUMP_OFF;
      end else begin
         gain_cmd_o  <= gain_d;
         clamp_cmd_o <= clamp_d;
      end
   end
endmodule

// File: rtl/vid_gain_clamp_ctrl.sv
`timescale 1ns/1ps
module vid_gain_clamp_ctrl #(
   parameter int CODE_W     = 8,
   parameter int PEAK_CODE  = 248,
   parameter int BLACK_CODE = 64,
   parameter int MIN_HIGH   = 64,
   parameter int WIN        = 512,
   parameter int LINE_LEN   = 2048,
   parameter int N_PAIRS    = 4,
   parameter int M_MISS     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  logic              under_i,
   input  logic              over_i,
   input  logic              sync_gate_i,
   input  logic              porch_gate_i,
   output logic [2:0]        gain_cmd_o,
   output logic [2:0]        clamp_cmd_o,
   output logic              fine_mode_o
);
   localparam int NUM_GATES = 2;
   localparam int SYNC_IDX  = 0;
   localparam int PORCH_IDX = 1;

   // elaboration-time parameter checks
   if (CODE_W < 2 || PEAK_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("PEAK_CODE must fit in CODE_W bits");
   end
   if (BLACK_CODE < 1 || BLACK_CODE >= PEAK_CODE) begin : g_bad_black
      $error("BLACK_CODE must lie between 1 and PEAK_CODE");
   end
   if (MIN_HIGH < 1 || WIN < 1) begin : g_bad_pulse
      $error("MIN_HIGH and WIN must be positive");
   end
   if (LINE_LEN <= WIN || N_PAIRS < 1 || M_MISS < 1) begin : g_bad_line
      $error("LINE_LEN must exceed WIN; N_PAIRS and M_MISS must be positive");
   end

   logic [NUM_GATES-1:0] gate_v, end_v;
   assign gate_v[SYNC_IDX]  = sync_gate_i;
   assign gate_v[PORCH_IDX] = porch_gate_i;

   for (genvar g = 0; g < NUM_GATES; g++) begin : g_qual
      vgc_pulse_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
         .clk         (clk),
         .rst_n       (rst_n),
         .strobe_i    (gate_v[g]),
         .valid_end_o (end_v[g])
      );
   end

   vgc_mode_fsm #(
      .WIN(WIN), .LINE_LEN(LINE_LEN), .N_PAIRS(N_PAIRS), .M_MISS(M_MISS)
   ) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_end_i  (end_v[SYNC_IDX]),
      .porch_end_i (end_v[PORCH_IDX]),
      .fine_o      (fine_mode_o)
   );

   vgc_pump_decode #(
      .CODE_W(CODE_W), .PEAK_CODE(PEAK_CODE), .BLACK_CODE(BLACK_CODE)
   ) u_pump (
      .clk         (clk),
      .rst_n       (rst_n),
      .fine_i      (fine_mode_o),
      .code_i      (code_i),
      .under_i     (under_i),
      .over_i      (over_i),
      .sync_i      (sync_gate_i),
      .porch_i     (porch_gate_i),
      .gain_cmd_o  (gain_cmd_o),
      .clamp_cmd_o (clamp_cmd_o)
   );
endmodule

// File: rtl/vgc_checker.sv
`timescale 1ns/1ps
module vgc_checker #(
   parameter int CODE_W    = 8,
   parameter int PEAK_CODE = 248
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] code_i,
   input logic              under_i,
   input logic              over_i,
   input logic              sync_gate_i,
   input logic              porch_gate_i,
   input logic [2:0]        gain_cmd_o,
   input logic [2:0]        clamp_cmd_o,
   input logic              fine_mode_o
);
   localparam logic [CODE_W-1:0] PEAK = CODE_W'(PEAK_CODE);

   p_legal_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_cmd_o inside {3'd0, 3'd1, 3'd2, 3'd5}) &&
      (clamp_cmd_o inside {3'd0, 3'd2, 3'd3, 3'd4, 3'd5}));

   p_coarse_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fine_mode_o |=> gain_cmd_o == ($past(over_i) ? 3'd5 : 3'd2));

   p_peak_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fine_mode_o && !under_i && (over_i || code_i > PEAK)) |=> gain_cmd_o == 3'd5);

   p_gain_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fine_mode_o && !sync_gate_i && !over_i && code_i <= PEAK) |=> gain_cmd_o == 3'd0);

   p_clamp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fine_mode_o && !porch_gate_i) |=> clamp_cmd_o == 3'd0);

   p_mode_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fine_mode_o) |-> (!$past(porch_gate_i) && $past(porch_gate_i, 2)));
endmodule

bind vid_gain_clamp_ctrl vgc_checker #(.CODE_W(CODE_W), .PEAK_CODE(PEAK_CODE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .code_i       (code_i),
   .under_i      (under_i),
   .over_i       (over_i),
   .sync_gate_i  (sync_gate_i),
   .porch_gate_i (porch_gate_i),
   .gain_cmd_o   (gain_cmd_o),
   .clamp_cmd_o  (clamp_cmd_o),
   .fine_mode_o  (fine_mode_o)
);

// File: tb/vid_gain_clamp_ctrl_tb.sv
`timescale 1ns/1ps
module vid_gain_clamp_ctrl_tb;
   localparam int MINH  = 8;
   localparam int WINL  = 40;
   localparam int LINE  = 120;
   localparam int NPAIR = 3;
   localparam int MMISS = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] code = 8'd0;
   logic       under = 1'b0, over = 1'b0, sync = 1'b0, porch = 1'b0;
   logic [2:0] gain_cmd, clamp_cmd;
   logic       fine_mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vid_gain_clamp_ctrl #(
      .MIN_HIGH(MINH), .WIN(WINL), .LINE_LEN(LINE), .N_PAIRS(NPAIR), .M_MISS(MMISS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .code_i(code), .under_i(under), .over_i(over),
      .sync_gate_i(sync), .porch_gate_i(porch),
      .gain_cmd_o(gain_cmd), .clamp_cmd_o(clamp_cmd), .fine_mode_o(fine_mode)
   );

   // ---------------- behavioural reference model ----------------
   int    m_gain, m_clamp;
   bit    m_fine;
   string g_tag = "R1", c_tag = "R1", f_tag = "R1";
   int    s_cnt, p_cnt, win, tmr, good, miss;
   bit    s_prev, p_prev;

   function automatic int f_gain(int v, bit fine, bit s, output string tag);
      if (!fine) begin tag = "R3"; return (v > 255) ? 5 : 2; end
      if (v > 248) begin tag = "R5"; return 5; end
      tag = "R6";
      if (!s) return 0;
      if (v < 0) return 1;
      if (v == 0) return 0;
      return 2;
   endfunction

   function automatic int f_clamp(int v, bit fine, bit s, bit p, output string tag);
      if (!fine) begin
         tag = "R4";
         if (!s || p) return 0;
         if (v < 0) return 5;
         if (v > 0) return 2;
         return 0;
      end
      tag = "R7";
      if (!p) return 0;
      if (v < 64) return 3;
      if (v > 64) return 4;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gain = 0; m_clamp = 0; m_fine = 0;
         s_cnt = 0; p_cnt = 0; win = 0; tmr = 0; good = 0; miss = 0;
         s_prev = 0; p_prev = 0;
         g_tag = "R1"; c_tag = "R1"; f_tag = "R1";
      end else begin
         int  v;
         bit  s_end, p_end, pair, tout, fine_n;
         v = under ? -1 : (over ? 256 : int'(code));
         m_gain  = f_gain(v, m_fine, sync, g_tag);
         m_clamp = f_clamp(v, m_fine, sync, porch, c_tag);
         s_end = s_prev && !sync && (s_cnt >= MINH);
         p_end = p_prev && !porch && (p_cnt >= MINH);
         pair  = p_end && (win > 0);
         tout  = !pair && (tmr == LINE - 1);
         fine_n = m_fine;
         if (pair && good + 1 >= NPAIR) fine_n = 1;
         else if (tout && miss + 1 >= MMISS) fine_n = 0;
         f_tag = (m_fine || fine_n) ? "R10" : "R9";
         if (fine_n && !m_fine) f_tag = "R9";
         m_fine = fine_n;
         if (s_end) win = WINL; else if (pair) win = 0; else if (win > 0) win = win - 1;
         tmr  = (pair || tout) ? 0 : tmr + 1;
         if (pair) begin good = (good < NPAIR) ? good + 1 : good; miss = 0; end
         else if (tout) begin good = 0; miss = (miss < MMISS) ? miss + 1 : miss; end
         s_cnt = sync ? ((s_cnt < MINH) ? s_cnt + 1 : s_cnt) : 0;
         p_cnt = porch ? ((p_cnt < MINH) ? p_cnt + 1 : p_cnt) : 0;
         s_prev = sync; p_prev = porch;
      end
   end

   task automatic check(bit ok, string tag, string what, int got, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
      end
   endtask

   // per-clock comparison, sampled between edges
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(int'(gain_cmd) == m_gain, g_tag, "gain_cmd", gain_cmd, m_gain);
         check(int'(clamp_cmd) == m_clamp, c_tag, "clamp_cmd", clamp_cmd, m_clamp);
         check(fine_mode == m_fine, f_tag, "fine_mode", fine_mode, m_fine);
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(bit s, bit p, int v);
      sync = s; porch = p;
      under = (v < 0); over = (v > 255);
      code = (v < 0) ? 8'd0 : ((v > 255) ? 8'd255 : 8'(v));
      @(negedge clk);
   endtask

   function automatic int sync_code(int i);
      case (i % 4)
         0: return -1;
         1: return 0;
         2: return 1;
         default: return int'($urandom_range(0, 252));
      endcase
   endfunction

   function automatic int porch_code(int i);
      case (i % 7)
         0: return 62;
         1: return 63;
         2: return 64;
         3: return 65;
         4: return 249;
         5: return -1;
         default: return 256;
      endcase
   endfunction

   function automatic int act_code();
      int r;
      r = int'($urandom_range(0, 15));
      if (r == 0) return 256;
      if (r == 1) return -1;
      if (r == 2) return 248;
      if (r == 3) return 249;
      return int'($urandom_range(0, 255));
   endfunction

   task automatic run_line(int slen, int gap, int plen, int act, int ovl);
      for (int i = 0; i < slen; i++) drive(1'b1, (ovl > 0) && (i >= slen - ovl), sync_code(i));
      for (int i = 0; i < gap; i++)  drive(1'b0, 1'b0, act_code());
      for (int i = 0; i < plen; i++) drive(1'b0, 1'b1, porch_code(i));
      for (int i = 0; i < act; i++)  drive(1'b0, 1'b0, act_code());
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state held while reset is low
      check(gain_cmd == 3'd0 && clamp_cmd == 3'd0 && !fine_mode, "R1", "reset outputs",
            {fine_mode, gain_cmd, clamp_cmd}, 0);
      rst_n = 1'b1;
      #1;
      check(gain_cmd == 3'd0 && !fine_mode, "R1", "after release", gain_cmd, 0);
      drive(1'b0, 1'b0, 100);
      // R2: over flag applied now must not show before the next edge
      sync = 0; porch = 0; over = 1'b1; code = 8'd255;
      #1;
      check(gain_cmd == 3'd2, "R2", "gain before edge", gain_cmd, 2);
      @(negedge clk);
      check(gain_cmd == 3'd5, "R2", "gain after edge", gain_cmd, 5);
      drive(1'b0, 1'b0, 10);

      // R8: pulses one sample short never qualify
      for (int k = 0; k < NPAIR + 1; k++) run_line(MINH - 1, 4, MINH - 1, 60, 0);
      for (int k = 0; k < NPAIR + 1; k++) run_line(12, 4, MINH - 1, 60, 0);
      check(!fine_mode, "R8", "short pulses", fine_mode, 0);

      // R9: porch beyond the window does not pair
      for (int k = 0; k < NPAIR + 1; k++) run_line(10, WINL + 5, 10, 60, 0);
      check(!fine_mode, "R9", "late porch", fine_mode, 0);

      // R9: well-formed pairs reach fine mode
      for (int k = 0; k < NPAIR; k++) run_line(10, 4, 10, 60, 0);
      check(fine_mode, "R9", "acquired", fine_mode, 1);

      // R5/R6/R7: fine lines, strobes overlapping
      for (int k = 0; k < 6; k++) run_line(10, 0, 8, 60, 4);
      check(fine_mode, "R9", "held with overlap", fine_mode, 1);

      // R10: one missed line tolerated, second drops to coarse
      for (int i = 0; i < LINE + 5; i++) drive(1'b0, 1'b0, act_code());
      check(fine_mode, "R10", "one miss", fine_mode, 1);
      for (int i = 0; i < LINE + 5; i++) drive(1'b0, 1'b0, act_code());
      check(!fine_mode, "R10", "fallback", fine_mode, 0);

      // reacquire then reset mid-run
      for (int k = 0; k < NPAIR + 2; k++) run_line(9, 2, 9, 50, 0);
      check(fine_mode, "R9", "reacquired", fine_mode, 1);
      #2 rst_n = 1'b0;
      #1;
      check(gain_cmd == 3'd0 && clamp_cmd == 3'd0 && !fine_mode, "R1", "mid-run reset",
            {fine_mode, gain_cmd, clamp_cmd}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 2; k++) run_line(10, 4, 10, 60, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule